// File: doc/BRIEF.md
# Segmented Dot-Product Accumulator

This block forms the signed inner product of two vectors of length `VEC_LEN` while instantiating only `LANES` multipliers. Each operand arrives as a stream of slices of `LANES` elements, one slice per accepted cycle. In each accepted cycle the block multiplies the matching lanes, reduces the lane products to one partial sum in a balanced adder tree, and folds that partial sum into a single running accumulator. After `VEC_LEN / LANES` slices the complete inner product is presented together with a one-cycle valid pulse.

The producer marks the opening slice of a vector pair with a start flag and the closing slice with an end flag. The start flag reloads the accumulator rather than adding to it, so consecutive inner products can stream with no bubble. When both operands carry the same column, the result is that column's squared norm. The multiplier count is a compile-time choice: `LANES = VEC_LEN` gives a fully parallel single-cycle-per-vector unit, and `LANES = 1` gives a fully serial one.

Top module: `seg_dot_acc`

## Requirements
- R1: When `dot_vld_o` is high, `dot_o` equals the exact signed sum of `op_a` element times `op_b` element over every accepted slice from the start-flagged slice through the end-flagged slice.
- R2: Lane j of a slice occupies bits `[j*DATA_W +: DATA_W]` of `op_a_i` and `op_b_i` and is a two's-complement value. Vector element k is lane `k % LANES` of slice `k / LANES`.
- R3: `dot_o` is `2*DATA_W + clog2(VEC_LEN)` bits wide and signed. It returns the exact result for every input, including every element at the most negative value, so its magnitude never exceeds `VEC_LEN * 2^(2*DATA_W-2)`.
- R4: An accepted slice with `slice_first_i` high replaces the accumulator contents with its own partial sum, so a new inner product may start in the cycle right after the previous end slice.
- R5: `dot_vld_o` is high for exactly one cycle, after the third rising edge counted from and including the edge that accepts an end-flagged slice. It is low in every other cycle.
- R6: A cycle with `slice_vld_i` low is ignored whatever the data and flags. It does not change the result, it does not produce a valid pulse, and `dot_o` holds its value once earlier slices have drained.
- R7: A slice flagged as both start and end yields the inner product of that slice alone. With `LANES = VEC_LEN` every vector is handled this way.
- R8: With equal operands the result is the sum of squares of the elements, which is never negative.
- R9: While `rst_ni` is low, `dot_vld_o` and `dot_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slice_vld_i | input | 1 | The current slice is to be accepted |
| slice_first_i | input | 1 | The slice opens a new inner product |
| slice_last_i | input | 1 | The slice closes the inner product |
| op_a_i | input | LANES*DATA_W | First operand slice, lane j at bits j*DATA_W |
| op_b_i | input | LANES*DATA_W | Second operand slice, same layout |
| dot_o | output | 2*DATA_W+clog2(VEC_LEN) | Accumulated signed inner product |
| dot_vld_o | output | 1 | One-cycle pulse marking a finished result |

## Verification
In every cycle the assertions check the timing of the valid pulse against the accepted end slices, that the result holds while no slice drains into it, the magnitude bound on every presented result, and the reset state. The arithmetic cannot be shown that way. The bench scenarios compare results with a reference inner product over fixed vectors at three lane counts (partial, fully parallel and fully serial), and cover extreme values, squared norms, back-to-back vectors and idle gaps filled with garbage data and flags.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } sdp_tag_t;

  function automatic int sdp_acc_width(int data_w, int vec_len);
    return 2 * data_w + $clog2(vec_len);
  endfunction

endpackage

// File: rtl/sdp_mul_bank.sv
module sdp_mul_bank
  import sdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  sdp_tag_t                      tag_i,
  input  logic [LANES*DATA_W-1:0]       a_i,
  input  logic [LANES*DATA_W-1:0]       b_i,
  output sdp_tag_t                      tag_o,
  output logic [LANES*2*DATA_W-1:0]     prod_o
);

  localparam int PROD_W = 2 * DATA_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [PROD_W-1:0] a_ext, b_ext, prod_q;

    assign a_ext = PROD_W'($signed(a_i[j*DATA_W +: DATA_W]));
    assign b_ext = PROD_W'($signed(b_i[j*DATA_W +: DATA_W]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        prod_q <= '0;
      else if (tag_i.vld) prod_q <= a_ext * b_ext;
    end

    assign prod_o[j*PROD_W +: PROD_W] = prod_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_o <= '0;
    else         tag_o <= tag_i;
  end

endmodule

// File: rtl/sdp_add_tree.sv
module sdp_add_tree
  import sdp_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int LANES = 4,
  parameter int OUT_W = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  sdp_tag_t                tag_i,
  input  logic [LANES*IN_W-1:0]   terms_i,
  output sdp_tag_t                tag_o,
  output logic [OUT_W-1:0]        sum_o
);

  localparam int DEPTH = $clog2(LANES);
  localparam int PAD   = 1 << DEPTH;
  localparam int NODES = 2 * PAD - 1;

  // heap layout: node 0 is the root, leaves start at PAD-1
  logic signed [OUT_W-1:0] node [NODES];

  for (genvar g = 0; g < PAD; g++) begin : g_leaf
    if (g < LANES) begin : g_real
      assign node[PAD-1+g] = OUT_W'($signed(terms_i[g*IN_W +: IN_W]));
    end else begin : g_pad
      assign node[PAD-1+g] = '0;
    end
  end

  for (genvar i = 0; i < PAD - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      tag_o <= '0;
    end else begin
      tag_o <= tag_i;
      if (tag_i.vld) sum_o <= node[0];
    end
  end

endmodule

// File: rtl/sdp_accum.sv
module sdp_accum
  import sdp_pkg::*;
#(
  parameter int ACC_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sdp_tag_t         tag_i,
  input  logic [ACC_W-1:0] part_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             done_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= tag_i.vld & tag_i.last;
      if (tag_i.vld) acc_o <= tag_i.first ? part_i : acc_o + part_i;
    end
  end

endmodule

// File: rtl/seg_dot_acc.sv
module seg_dot_acc
  import sdp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int VEC_LEN = 16,
  parameter int LANES   = 4
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      slice_vld_i,
  input  logic                                      slice_first_i,
  input  logic                                      slice_last_i,
  input  logic [LANES*DATA_W-1:0]                   op_a_i,
  input  logic [LANES*DATA_W-1:0]                   op_b_i,
  output logic [sdp_acc_width(DATA_W, VEC_LEN)-1:0] dot_o,
  output logic                                      dot_vld_o
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = sdp_acc_width(DATA_W, VEC_LEN);

  sdp_tag_t                    tag_in, tag_mul, tag_sum;
  logic [LANES*PROD_W-1:0]     prods;
  logic [ACC_W-1:0]            partial;

  assign tag_in = '{vld: slice_vld_i, first: slice_first_i, last: slice_last_i};

  sdp_mul_bank #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) i_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (tag_in),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .tag_o  (tag_mul),
    .prod_o (prods)
  );

  sdp_add_tree #(
    .IN_W  (PROD_W),
    .LANES (LANES),
    .OUT_W (ACC_W)
  ) i_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tag_i   (tag_mul),
    .terms_i (prods),
    .tag_o   (tag_sum),
    .sum_o   (partial)
  );

  sdp_accum #(
    .ACC_W (ACC_W)
  ) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (tag_sum),
    .part_i (partial),
    .acc_o  (dot_o),
    .done_o (dot_vld_o)
  );

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int DATA_W  = 16,
  parameter int VEC_LEN = 16,
  parameter int ACC_W   = 36
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slice_vld_i,
  input logic             slice_last_i,
  input logic [ACC_W-1:0] dot_o,
  input logic             dot_vld_o
);

  localparam logic signed [ACC_W-1:0] BOUND = ACC_W'(VEC_LEN) << (2 * DATA_W - 2);

  logic [2:0] vld_d, end_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_d <= '0;
      end_d <= '0;
    end else begin
      vld_d <= {vld_d[1:0], slice_vld_i};
      end_d <= {end_d[1:0], slice_vld_i & slice_last_i};
    end
  end

  assert_pulse_after_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_d[2] |-> dot_vld_o);

  assert_no_stray_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_vld_o |-> end_d[2]);

  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_d[2] |-> $stable(dot_o));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_vld_o |-> ($signed(dot_o) <= BOUND && $signed(dot_o) >= -BOUND));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R9: assert (dot_vld_o == 1'b0 && dot_o == '0);
    end
  end

endmodule

bind seg_dot_acc sdp_checker #(
  .DATA_W  (DATA_W),
  .VEC_LEN (VEC_LEN),
  .ACC_W   (ACC_W)
) i_sdp_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slice_vld_i  (slice_vld_i),
  .slice_last_i (slice_last_i),
  .dot_o        (dot_o),
  .dot_vld_o    (dot_vld_o)
);

// File: tb/test_seg_dot_acc.sv
`timescale 1ns/1ps
module test_seg_dot_acc;

  localparam int DW = 8;
  localparam int VL = 8;
  localparam int AW = 2 * DW + $clog2(VL);

  // {op_a, op_b}; element k at bits [k*8 +: 8]
  localparam logic [127:0] VEC_TAB [6] = '{
    {64'h0102030405060708, 64'h0101010101010101},
    {64'hFFFEFDFC04030201, 64'h7F80017F80017F80},
    {64'h8080808080808080, 64'h8080808080808080},
    {64'h7F7F7F7F7F7F7F7F, 64'h8080808080808080},
    {64'h0000000000000000, 64'h123456789ABCDEF0},
    {64'hA5C3E10F5A3C1EF0, 64'hA5C3E10F5A3C1EF0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic m_vld, m_first, m_last; logic [31:0] m_a, m_b; logic [AW-1:0] m_dot; logic m_dv;
  logic f_vld, f_first, f_last; logic [63:0] f_a, f_b; logic [AW-1:0] f_dot; logic f_dv;
  logic s_vld, s_first, s_last; logic [7:0]  s_a, s_b; logic [AW-1:0] s_dot; logic s_dv;

  seg_dot_acc #(.DATA_W(DW), .VEC_LEN(VL), .LANES(4)) i_seg_dot_acc (
    .clk_i(clk), .rst_ni(rst_ni), .slice_vld_i(m_vld), .slice_first_i(m_first),
    .slice_last_i(m_last), .op_a_i(m_a), .op_b_i(m_b), .dot_o(m_dot), .dot_vld_o(m_dv));

  seg_dot_acc #(.DATA_W(DW), .VEC_LEN(VL), .LANES(8)) i_seg_dot_acc_par (
    .clk_i(clk), .rst_ni(rst_ni), .slice_vld_i(f_vld), .slice_first_i(f_first),
    .slice_last_i(f_last), .op_a_i(f_a), .op_b_i(f_b), .dot_o(f_dot), .dot_vld_o(f_dv));

  seg_dot_acc #(.DATA_W(DW), .VEC_LEN(VL), .LANES(1)) i_seg_dot_acc_ser (
    .clk_i(clk), .rst_ni(rst_ni), .slice_vld_i(s_vld), .slice_first_i(s_first),
    .slice_last_i(s_last), .op_a_i(s_a), .op_b_i(s_b), .dot_o(s_dot), .dot_vld_o(s_dv));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  int m_cnt = 0, f_cnt = 0, s_cnt = 0;
  longint m_got = 0, m_prev = 0, f_got = 0, s_got = 0;

  always @(negedge clk) begin
    if (m_dv) begin m_prev = m_got; m_got = longint'($signed(m_dot)); m_cnt++; end
    if (f_dv) begin f_got = longint'($signed(f_dot)); f_cnt++; end
    if (s_dv) begin s_got = longint'($signed(s_dot)); s_cnt++; end
  end

  function automatic longint ref_dot(input logic [63:0] a, input logic [63:0] b);
    longint acc = 0;
    for (int k = 0; k < 8; k++)
      acc += longint'($signed(a[k*8 +: 8])) * longint'($signed(b[k*8 +: 8]));
    return acc;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic report();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      failures++;
      $display("FAIL watchdog got=%0d exp=<100000 cycles", cyc);
      report();
    end
  end

  task automatic idle_all();
    m_vld = 0; f_vld = 0; s_vld = 0;
  endtask

  task automatic main_slice(input logic v, input logic fst, input logic lst,
                            input logic [31:0] a, input logic [31:0] b);
    m_vld = v; m_first = fst; m_last = lst; m_a = a; m_b = b;
    @(negedge clk);
  endtask

  task automatic drive_all(input logic [63:0] a, input logic [63:0] b);
    for (int c = 0; c < 8; c++) begin
      m_vld = (c < 2); m_first = (c == 0); m_last = (c == 1);
      m_a = (c < 2) ? a[(c%2)*32 +: 32] : $urandom;
      m_b = (c < 2) ? b[(c%2)*32 +: 32] : $urandom;
      f_vld = (c == 0); f_first = 1'b1; f_last = 1'b1;
      f_a = (c == 0) ? a : {$urandom, $urandom};
      f_b = (c == 0) ? b : {$urandom, $urandom};
      s_vld = 1'b1; s_first = (c == 0); s_last = (c == 7);
      s_a = a[c*8 +: 8]; s_b = b[c*8 +: 8];
      @(negedge clk);
    end
    idle_all();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    idle_all();
    m_first = 0; m_last = 0; m_a = 0; m_b = 0;
    f_first = 0; f_last = 0; f_a = 0; f_b = 0;
    s_first = 0; s_last = 0; s_a = 0; s_b = 0;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 valid", longint'({m_dv, f_dv, s_dv}), 0);
    check("R9 dot", longint'($signed(m_dot)), 0);
    check("R9 dot par/ser", longint'(f_dot | s_dot), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk at three lane counts
    for (int i = 0; i < 6; i++) begin
      logic [63:0] va, vb;
      longint exp;
      int mc, fc, sc;
      string tag;
      va = VEC_TAB[i][127:64]; vb = VEC_TAB[i][63:0];
      exp = ref_dot(va, vb);
      tag = (i == 2 || i == 3) ? "R3" : (i == 5) ? "R8" : "R1";
      mc = m_cnt; fc = f_cnt; sc = s_cnt;
      drive_all(va, vb);
      check({tag, " lanes=4"}, m_got, exp);
      check("R7 lanes=8", f_got, exp);
      check("R2 lanes=1", s_got, exp);
      check("R5 one pulse per vector", longint'(m_cnt - mc + f_cnt - fc + s_cnt - sc), 3);
    end

    // R5 exact latency
    main_slice(1, 1, 0, VEC_TAB[0][95:64], VEC_TAB[0][31:0]);
    main_slice(1, 0, 1, VEC_TAB[0][127:96], VEC_TAB[0][63:32]);
    m_vld = 0;
    @(negedge clk); check("R5 low after 1 edge", longint'(m_dv), 0);
    @(negedge clk); check("R5 high after 2 edges", longint'(m_dv), 1);
    @(negedge clk); check("R5 low after 3 edges", longint'(m_dv), 0);
    repeat (3) @(negedge clk);

    // R4 back-to-back vectors, no idle cycle
    begin
      int mc;
      mc = m_cnt;
      main_slice(1, 1, 0, VEC_TAB[0][95:64], VEC_TAB[0][31:0]);
      main_slice(1, 0, 1, VEC_TAB[0][127:96], VEC_TAB[0][63:32]);
      main_slice(1, 1, 0, VEC_TAB[1][95:64], VEC_TAB[1][31:0]);
      main_slice(1, 0, 1, VEC_TAB[1][127:96], VEC_TAB[1][63:32]);
      m_vld = 0;
      repeat (5) @(negedge clk);
      check("R4 pulses", longint'(m_cnt - mc), 2);
      check("R4 first result", m_prev, ref_dot(VEC_TAB[0][127:64], VEC_TAB[0][63:0]));
      check("R4 second result", m_got, ref_dot(VEC_TAB[1][127:64], VEC_TAB[1][63:0]));
    end

    // R6 idle gap with garbage data and flags
    begin
      int mc;
      longint held;
      mc = m_cnt;
      main_slice(1, 1, 0, VEC_TAB[5][95:64], VEC_TAB[5][31:0]);
      for (int g = 0; g < 4; g++) main_slice(0, 1, 1, $urandom, $urandom);
      held = longint'($signed(m_dot));
      main_slice(0, 1, 1, $urandom, $urandom);
      check("R6 dot holds in gap", longint'($signed(m_dot)), held);
      check("R6 no pulse in gap", longint'(m_cnt - mc), 0);
      main_slice(1, 0, 1, VEC_TAB[5][127:96], VEC_TAB[5][63:32]);
      m_vld = 0;
      repeat (5) @(negedge clk);
      check("R6 result across gap", m_got, ref_dot(VEC_TAB[5][127:64], VEC_TAB[5][63:0]));
      check("R6 single pulse", longint'(m_cnt - mc), 1);
    end

    // R7 start and end on one slice with partial lanes
    main_slice(1, 1, 1, VEC_TAB[1][95:64], VEC_TAB[1][31:0]);
    m_vld = 0;
    repeat (5) @(negedge clk);
    check("R7 single slice", m_got, ref_dot({32'h0, VEC_TAB[1][95:64]}, {32'h0, VEC_TAB[1][31:0]}));

    report();
  end

endmodule